// File: doc/BRIEF.md
# Two-Point Linear Calibration Corrector

This block turns raw converter codes into corrected codes through a straight-line fit. A caller places two raw readings on the reference inputs, taken with the converter looking at one quarter and three quarters of full scale, and pulses a start strobe. The block derives a fixed-point gain from them with a sequential divider, using one million as the unit of gain. It then derives an offset from the lower reading and installs both coefficients in the same clock edge.

Every raw sample that arrives while no calibration is running is masked to the data width, multiplied by the gain, scaled back down by one million, shifted by the offset and saturated to the legal code range. While a calibration is in progress, incoming samples are dropped. A pair of readings that cannot define a rising line is refused with an error flag, and the coefficients in force stay in force.

Top module: `lincal_corrector`

## Requirements
- R1: After reset the gain is 1,000,000 and the offset is 0, so each accepted sample comes out equal to its masked raw value; cal_done, cal_err and out_valid are 0.
- R2: Only the low DATA_W bits of smp_raw take part in correction; the bits above them have no effect on out_code.
- R3: On a successful calibration the gain becomes floor(2^(DATA_W-1) * 1,000,000 / (ref_hi - ref_lo)), the difference of the nominal targets 3*2^DATA_W/4 and 2^DATA_W/4 being 2^(DATA_W-1).
- R4: The offset installed with that gain is 2^(DATA_W-2) minus floor(ref_lo * gain / 1,000,000), and may be negative.
- R5: An accepted sample produces floor(raw * gain / 1,000,000) + offset, forced to 0 when negative and to 2^DATA_W - 1 when above it.
- R6: A strobe accepted with ref_hi <= ref_lo sets cal_err on the next edge, leaves cal_done at 0 and changes neither coefficient.
- R7: After a strobe accepted with ref_hi > ref_lo on edge E0, cal_done rises on edge E0 + DATA_W + 20 with both coefficients at once; until that edge further strobes are ignored and samples presented on edges E0+1 to E0+DATA_W+20 are dropped.
- R8: A sample with smp_valid high on an edge where it is accepted appears on out_code with out_valid high after the second edge, and out_valid is low in every other cycle.
- R9: Any accepted strobe clears cal_done and, when its readings are valid, cal_err, on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_start | input | 1 | Start a calibration with the readings present this cycle |
| ref_lo | input | DATA_W | Raw reading taken at the quarter-scale reference |
| ref_hi | input | DATA_W | Raw reading taken at the three-quarter-scale reference |
| smp_valid | input | 1 | smp_raw holds a sample this cycle |
| smp_raw | input | IN_W | Raw sample; bits above DATA_W are ignored |
| out_valid | output | 1 | out_code holds a corrected sample |
| out_code | output | DATA_W | Corrected, saturated sample |
| cal_done | output | 1 | Coefficients from the last strobe are installed |
| cal_err | output | 1 | The last strobe was refused for degenerate readings |

## Verification
The properties assume that reset is held for at least three clock edges, so that every two-cycle look-back lands on reset values, and that smp_valid is low during reset. They also rely on strobes arriving only from the caller's side, with no assumption on their spacing, since the block must itself ignore strobes while busy. The stimulus keeps reset and sample valid in that shape, and otherwise drives random samples including all upper bits, strobes inside a running calibration, equal and inverted reference pairs, and readings one code apart, which give the largest gain.

// File: rtl/lincal_pkg.sv
package lincal_pkg;

    // calibration sequencer states
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } cal_state_e;

endpackage

// File: rtl/lincal_divider.sv
// Restoring unsigned divider: one quotient bit per clock, MSB first.
module lincal_divider #(
    parameter int NUM_W = 31,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        r_d   = r_q;
        trial = {r_q.rem, r_q.quo[NUM_W-1]};
        fits  = (trial >= {1'b0, r_q.den});
        if (start) begin
            r_d.quo = num;
            r_d.rem = '0;
            r_d.den = den;
            r_d.cnt = CNT_W'(NUM_W);
        end else if (r_q.cnt != '0) begin
            r_d.rem = fits ? DEN_W'(trial - {1'b0, r_q.den}) : trial[DEN_W-1:0];
            r_d.quo = {r_q.quo[NUM_W-2:0], fits};
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.cnt != '0);
    assign quo  = r_q.quo;

endmodule

// File: rtl/lincal_scale.sv
// Unsigned product of a code and a gain, brought back down by the gain unit.
module lincal_scale #(
    parameter int X_W    = 12,
    parameter int GAIN_W = 31,
    parameter int SCALE  = 1000000
) (
    input  logic [X_W-1:0]        x,
    input  logic [GAIN_W-1:0]     gain,
    output logic [X_W+GAIN_W-1:0] y
);
    localparam int PROD_W = X_W + GAIN_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(x) * PROD_W'(gain);
        y    = prod / PROD_W'(SCALE);
    end

endmodule

// File: rtl/lincal_corrector.sv
module lincal_corrector #(
    parameter int DATA_W = 12,
    parameter int IN_W   = 16,
    parameter int SCALE  = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start,
    input  logic [DATA_W-1:0] ref_lo,
    input  logic [DATA_W-1:0] ref_hi,
    input  logic              smp_valid,
    input  logic [IN_W-1:0]   smp_raw,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_code,
    output logic              cal_done,
    output logic              cal_err
);
    import lincal_pkg::*;

    localparam int SCALE_W  = $clog2(SCALE + 1);
    localparam int GAIN_W   = DATA_W - 1 + SCALE_W;
    localparam int OFF_W    = DATA_W + GAIN_W + 1;
    localparam int SMP_P_W  = IN_W + GAIN_W;
    localparam int SUM_W    = SMP_P_W + 2;
    localparam int NOM_LO   = 2 ** (DATA_W - 2);
    localparam int NOM_SPAN = 2 ** (DATA_W - 1);
    localparam logic [GAIN_W-1:0] DIV_NUM  = GAIN_W'(NOM_SPAN) * GAIN_W'(SCALE);
    localparam logic [GAIN_W-1:0] UNITY    = GAIN_W'(SCALE);
    localparam logic [IN_W-1:0]   RAW_MASK = {{(IN_W - DATA_W){1'b0}}, {DATA_W{1'b1}}};
    localparam logic [SUM_W-1:0]  CODE_MAX = SUM_W'({DATA_W{1'b1}});

    typedef struct packed {
        cal_state_e        state;
        logic [DATA_W-1:0] lo;
        logic [GAIN_W-1:0] gain;
        logic [OFF_W-1:0]  off;
        logic              done;
        logic              err;
        logic              v1;
        logic [IN_W-1:0]   raw1;
        logic              ov;
        logic [DATA_W-1:0] oc;
    } regs_t;

    regs_t r_d, r_q;

    logic                      go, bad;
    logic                      div_busy;
    logic [GAIN_W-1:0]         div_quo;
    logic [DATA_W+GAIN_W-1:0]  lo_scaled;
    logic [SMP_P_W-1:0]        smp_scaled;
    logic [OFF_W-1:0]          off_new;
    logic signed [SUM_W-1:0]   sum;
    logic [DATA_W-1:0]         clamped;

    // signals exposed to the bound checker
    logic              cal_busy;
    logic [GAIN_W-1:0] gain_now;
    logic [OFF_W-1:0]  off_now;

    lincal_divider #(
        .NUM_W (GAIN_W),
        .DEN_W (DATA_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (go && !bad),
        .num   (DIV_NUM),
        .den   (ref_hi - ref_lo),
        .busy  (div_busy),
        .quo   (div_quo)
    );

    lincal_scale #(
        .X_W    (DATA_W),
        .GAIN_W (GAIN_W),
        .SCALE  (SCALE)
    ) u_scale_lo (
        .x    (r_q.lo),
        .gain (div_quo),
        .y    (lo_scaled)
    );

    lincal_scale #(
        .X_W    (IN_W),
        .GAIN_W (GAIN_W),
        .SCALE  (SCALE)
    ) u_scale_smp (
        .x    (r_q.raw1),
        .gain (r_q.gain),
        .y    (smp_scaled)
    );

    always_comb begin
        r_d  = r_q;
        go   = (r_q.state == ST_IDLE) && cal_start;
        bad  = (ref_hi <= ref_lo);

        off_new = OFF_W'(NOM_LO) - OFF_W'(lo_scaled);

        sum = $signed(SUM_W'(smp_scaled))
            + $signed({{(SUM_W - OFF_W){r_q.off[OFF_W-1]}}, r_q.off});
        if (sum[SUM_W-1]) begin
            clamped = '0;
        end else if (unsigned'(sum) > CODE_MAX) begin
            clamped = {DATA_W{1'b1}};
        end else begin
            clamped = sum[DATA_W-1:0];
        end

        // sample path: accept, then correct on the following edge
        r_d.v1   = smp_valid && (r_q.state == ST_IDLE);
        r_d.raw1 = smp_raw & RAW_MASK;
        r_d.ov   = r_q.v1;
        if (r_q.v1) begin
            r_d.oc = clamped;
        end

        // calibration sequencing
        case (r_q.state)
            ST_IDLE: begin
                if (go) begin
                    r_d.done = 1'b0;
                    r_d.err  = bad;
                    if (!bad) begin
                        r_d.lo    = ref_lo;
                        r_d.state = ST_DIVIDE;
                    end
                end
            end
            ST_DIVIDE: begin
                if (!div_busy) begin
                    r_d.gain  = div_quo;
                    r_d.off   = off_new;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.gain  <= UNITY;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_code  = r_q.oc;
    assign cal_done  = r_q.done;
    assign cal_err   = r_q.err;
    assign cal_busy  = (r_q.state != ST_IDLE);
    assign gain_now  = r_q.gain;
    assign off_now   = r_q.off;

endmodule

// File: rtl/lincal_checker.sv
module lincal_checker #(
    parameter int DATA_W = 12,
    parameter int GAIN_W = 31,
    parameter int OFF_W  = 44
) (
    input logic              clk,
    input logic              rst,
    input logic              cal_start,
    input logic [DATA_W-1:0] ref_lo,
    input logic [DATA_W-1:0] ref_hi,
    input logic              smp_valid,
    input logic              out_valid,
    input logic              cal_done,
    input logic              cal_err,
    input logic              busy,
    input logic [GAIN_W-1:0] gain,
    input logic [OFF_W-1:0]  off
);

    assert_err_not_done_R6: assert property (@(posedge clk) disable iff (rst)
        cal_err |-> !cal_done);

    assert_bad_refs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cal_start && !busy && (ref_hi <= ref_lo)) |=> cal_err);

    assert_err_keeps_coeff_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_err) |-> ($stable(gain) && $stable(off)));

    assert_busy_drops_samples_R7: assert property (@(posedge clk) disable iff (rst)
        $past(busy, 2) |-> !out_valid);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> $past(busy));

    assert_coeff_frozen_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(gain) && $stable(off)));

    assert_out_two_edges_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(smp_valid, 2));

    assert_start_clears_done_R9: assert property (@(posedge clk) disable iff (rst)
        (cal_start && !busy) |=> !cal_done);

endmodule

bind lincal_corrector lincal_checker #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .OFF_W  (OFF_W)
) u_lincal_checker (
    .clk       (clk),
    .rst       (rst),
    .cal_start (cal_start),
    .ref_lo    (ref_lo),
    .ref_hi    (ref_hi),
    .smp_valid (smp_valid),
    .out_valid (out_valid),
    .cal_done  (cal_done),
    .cal_err   (cal_err),
    .busy      (cal_busy),
    .gain      (gain_now),
    .off       (off_now)
);

// File: tb/lincal_corrector_test.sv
`timescale 1ns/1ps
module lincal_corrector_test;
    localparam int DATA_W = 12;
    localparam int IN_W   = 16;
    localparam int SCALE  = 1000000;
    localparam int CAL_LAT = DATA_W + 20;
    localparam longint CODE_MAX = (64'd1 << DATA_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cal_start = 1'b0;
    logic [DATA_W-1:0] ref_lo = '0;
    logic [DATA_W-1:0] ref_hi = '0;
    logic              smp_valid = 1'b0;
    logic [IN_W-1:0]   smp_raw = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_code;
    logic              cal_done;
    logic              cal_err;

    int compared = 0;
    int mismatched = 0;
    string phase = "R1";

    lincal_corrector #(.DATA_W(DATA_W), .IN_W(IN_W), .SCALE(SCALE)) uut (
        .clk(clk), .rst(rst), .cal_start(cal_start), .ref_lo(ref_lo), .ref_hi(ref_hi),
        .smp_valid(smp_valid), .smp_raw(smp_raw), .out_valid(out_valid),
        .out_code(out_code), .cal_done(cal_done), .cal_err(cal_err)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    longint m_gain, m_off, pend_gain, pend_off;
    int     busy_cnt;
    bit     p_v, e_v, e_done, e_err;
    longint p_d, e_d;

    function automatic longint correct(input longint raw, input longint g, input longint o);
        longint v;
        v = ((raw & CODE_MAX) * g) / SCALE + o;
        if (v < 0) v = 0;
        if (v > CODE_MAX) v = CODE_MAX;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_gain = SCALE; m_off = 0; busy_cnt = 0;
            p_v = 0; e_v = 0; e_done = 0; e_err = 0; p_d = 0; e_d = 0;
        end else begin
            bit acc;
            e_v = p_v;
            if (p_v) e_d = p_d;
            acc = smp_valid && (busy_cnt == 0);
            p_v = acc;
            if (acc) p_d = correct(longint'(smp_raw), m_gain, m_off);
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    m_gain = pend_gain; m_off = pend_off; e_done = 1;
                end
            end else if (cal_start) begin
                e_done = 0;
                if (ref_hi <= ref_lo) begin
                    e_err = 1;
                end else begin
                    e_err = 0;
                    pend_gain = ((64'd1 << (DATA_W - 1)) * SCALE) / (longint'(ref_hi) - longint'(ref_lo));
                    pend_off  = (64'd1 << (DATA_W - 2)) - (longint'(ref_lo) * pend_gain) / SCALE;
                    busy_cnt  = CAL_LAT;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(out_valid == e_v, "out_valid", longint'(out_valid), longint'(e_v));
            if (e_v && out_valid)
                check(longint'(out_code) == e_d, "out_code", longint'(out_code), e_d);
            check(cal_done == e_done, "cal_done", longint'(cal_done), longint'(e_done));
            check(cal_err == e_err, "cal_err", longint'(cal_err), longint'(e_err));
        end
    end

    task automatic step(input bit st, input int lo, input int hi);
        @(negedge clk);
        cal_start = st;
        ref_lo    = DATA_W'(lo);
        ref_hi    = DATA_W'(hi);
        smp_valid = ($urandom_range(0, 3) != 0);
        smp_raw   = IN_W'($urandom);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    task automatic strobe(input int lo, input int hi);
        step(1'b1, lo, hi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired in phase %s actual=hung expected=finished", phase);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, unity pass-through
        @(negedge clk);
        check(!cal_done && !cal_err && !out_valid, "reset flags R1", 0, 0);
        run(20);
        // R2: upper bits of random raw samples must not matter
        phase = "R2"; run(30);
        // R3: ideal references give unity gain
        phase = "R3"; strobe(1024, 3072); run(45);
        // R7: strobe inside a running calibration is ignored
        phase = "R7"; strobe(900, 3100); run(5); strobe(1, 2); run(45);
        // R4: offset from a low reading off nominal
        phase = "R4"; strobe(700, 2900); run(45);
        // R6: equal and inverted readings are refused
        phase = "R6"; strobe(2000, 2000); run(6); strobe(3000, 1000); run(6);
        // R9: a good strobe clears the error
        phase = "R9"; strobe(1500, 2000); run(45);
        // R5: steep gain with negative offset saturates both ends
        phase = "R5"; run(80);
        // R8: back-to-back samples through the two-edge pipeline
        phase = "R8"; strobe(10, 4090); run(60);
        // R3: readings one code apart give the largest gain
        phase = "R3"; strobe(2047, 2048); run(45);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule